// File: doc/BRIEF.md
# Flowlet Next-Hop Selection Pipeline

This block chooses an output path for every packet using flowlet switching. Each cycle it may accept one packet, described by a source port, a destination port and an arrival timestamp. The port pair is folded into an index into a per-flowlet table. The ports and the timestamp together are folded into a candidate hop. For each table slot the block keeps two values: the time the flowlet was last seen and the hop it is currently pinned to. When a flowlet has been quiet for longer than the idle gap, its pinned hop moves to the new candidate. Otherwise packets keep following the pinned hop, so a burst stays on one path.

The datapath has six stages and a fixed latency. It accepts a packet every cycle and never stalls. Each of the two tables is read and rewritten inside a single stage. Because of this, a packet always sees the update made by the packet just before it in the same slot, and no forwarding network is needed. The stream has no ready signal: the block cannot apply back-pressure, and the consumer must take every result in the cycle `out_valid` is high. When `in_valid` is low, the port and time inputs are ignored.

Top module: `flowlet_nexthop`

## Requirements
- R1: The table index is `(sport XOR byte_swap(dport)) mod FLOW_ENTRIES`, with FLOW_ENTRIES defaulting to 2000. `byte_swap` exchanges the two bytes of the 16-bit destination port. Different port pairs that land on the same index share one table slot.
- R2: The candidate hop is `(sport + dport + arrival) mod NUM_HOPS`, computed without overflow. NUM_HOPS defaults to 10.
- R3: The pinned hop is replaced only when `(arrival - last_seen) mod 2^32` is strictly greater than IDLE_GAP, which defaults to 5. A gap exactly equal to IDLE_GAP keeps the pinned hop.
- R4: Every valid packet overwrites the last-seen time of its slot with its own arrival time, whether or not the gap was exceeded.
- R5: The next hop reported for a packet is the candidate when the gap was exceeded, and the pinned hop otherwise. It is always below NUM_HOPS.
- R6: After reset, every slot reads as last-seen time 0 and pinned hop 0.
- R7: A packet presented before clock edge E produces `out_valid` after edge E+5, which is the sixth edge counting E. Results leave in arrival order, one per cycle, with no stalls.
- R8: Back-to-back packets that share a slot each see the last-seen time and pinned hop written by the packet before them.
- R9: A cycle with `in_valid` low changes neither table and produces no result.
- R10: While `out_valid` is low, `out_hop` holds its previous value.
- R11: `out_valid` stays low for the first six cycles after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A packet is present this cycle |
| in_sport | input | 16 | Source port |
| in_dport | input | 16 | Destination port |
| in_arrival | input | 32 | Arrival timestamp |
| out_valid | output | 1 | A next-hop result is present this cycle |
| out_hop | output | 4 | Selected next hop |

## Verification
The first group of tests uses a single flow with hand-picked arrival gaps: a gap below the idle limit, a gap exactly at it, and a gap one above it. These show where the strict comparison sits and whether the last-seen time is refreshed even when the pinned hop is kept. The second group uses packets of one slot sent on consecutive cycles, including one sent right after a hop change. This exposes any stage that reads a table before the previous packet's write has landed. The third group covers two port pairs that collide on one index, an invalid cycle carrying conflicting data, and a timestamp that wraps past 2^32. The last group is long random multi-flow traffic with idle bubbles, compared packet by packet against a reference table model.

// File: rtl/flowlet_pkg.sv
package flowlet_pkg;
  // Default geometry shared by the top module and its checker.
  localparam int unsigned DEF_PORT_W  = 16;
  localparam int unsigned DEF_TIME_W  = 32;
  localparam int unsigned DEF_ENTRIES = 2000;
  localparam int unsigned DEF_HOPS    = 10;
  localparam int unsigned DEF_GAP     = 5;

  // Outcome of the idle-gap comparison, carried down the pipe.
  typedef enum logic {
    PICK_SAVED = 1'b0,
    PICK_FRESH = 1'b1
  } hop_pick_t;
endpackage

// File: rtl/flow_hash.sv
module flow_hash #(
  parameter int unsigned PORT_W  = 16,
  parameter int unsigned TIME_W  = 32,
  parameter int unsigned ENTRIES = 2000,
  parameter int unsigned HOPS    = 10,
  parameter int unsigned IDX_W   = 11,
  parameter int unsigned HOP_W   = 4
) (
  input  logic [PORT_W-1:0] sport,
  input  logic [PORT_W-1:0] dport,
  input  logic [TIME_W-1:0] arrival,
  output logic [IDX_W-1:0]  idx,
  output logic [HOP_W-1:0]  cand
);
  localparam int unsigned HALF_W = PORT_W / 2;
  localparam int unsigned SUM_W  = TIME_W + 2;

  logic [PORT_W-1:0] dswap;
  logic [PORT_W-1:0] key;
  logic [SUM_W-1:0]  sum;

  // R1: port pair folds to a slot index
  always_comb begin
    dswap = {dport[HALF_W-1:0], dport[PORT_W-1:HALF_W]};
    key   = sport ^ dswap;
    idx   = IDX_W'(32'(key) % 32'(ENTRIES));
  end

  // R2: ports plus timestamp fold to a candidate hop
  always_comb begin
    sum  = SUM_W'(sport) + SUM_W'(dport) + SUM_W'(arrival);
    cand = HOP_W'(sum % SUM_W'(HOPS));
  end
endmodule

// File: rtl/state_bank.sv
module state_bank #(
  parameter int unsigned DEPTH  = 2000,
  parameter int unsigned IDX_W  = 11,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  idx,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  live;

  // R6: a slot never written since reset reads as zero
  assign rd_data = live[idx] ? mem[idx] : '0;

  always_ff @(posedge clk) begin
    if (rst) live <= '0;
    else if (wr_en) live[idx] <= 1'b1;
  end

  // R8: read above and write here share one stage and one index
  always_ff @(posedge clk) begin
    if (wr_en) mem[idx] <= wr_data;
  end
endmodule

// File: rtl/flowlet_nexthop.sv
module flowlet_nexthop
  import flowlet_pkg::*;
#(
  parameter int unsigned PORT_W       = DEF_PORT_W,
  parameter int unsigned TIME_W       = DEF_TIME_W,
  parameter int unsigned FLOW_ENTRIES = DEF_ENTRIES,
  parameter int unsigned NUM_HOPS     = DEF_HOPS,
  parameter int unsigned IDLE_GAP     = DEF_GAP
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        in_valid,
  input  logic [PORT_W-1:0]           in_sport,
  input  logic [PORT_W-1:0]           in_dport,
  input  logic [TIME_W-1:0]           in_arrival,
  output logic                        out_valid,
  output logic [$clog2(NUM_HOPS)-1:0] out_hop
);
  localparam int unsigned IDX_W = $clog2(FLOW_ENTRIES);
  localparam int unsigned HOP_W = $clog2(NUM_HOPS);

  // Stage 1: hashes
  logic [IDX_W-1:0]  h_idx;
  logic [HOP_W-1:0]  h_cand;
  logic              v1;
  logic [IDX_W-1:0]  idx1;
  logic [HOP_W-1:0]  cand1;
  logic [TIME_W-1:0] arr1;

  flow_hash #(
    .PORT_W(PORT_W), .TIME_W(TIME_W), .ENTRIES(FLOW_ENTRIES),
    .HOPS(NUM_HOPS), .IDX_W(IDX_W), .HOP_W(HOP_W)
  ) u_hash (
    .sport(in_sport), .dport(in_dport), .arrival(in_arrival),
    .idx(h_idx), .cand(h_cand)
  );

  always_ff @(posedge clk) begin
    if (rst) v1 <= 1'b0;
    else v1 <= in_valid;
  end

  always_ff @(posedge clk) begin
    idx1  <= h_idx;
    cand1 <= h_cand;
    arr1  <= in_arrival;
  end

  // Stage 2: last-seen time, read and rewritten in one cycle (R4, R9)
  logic [TIME_W-1:0] last_rd;
  logic              v2;
  logic [IDX_W-1:0]  idx2;
  logic [HOP_W-1:0]  cand2;
  logic [TIME_W-1:0] arr2;
  logic [TIME_W-1:0] last2;

  state_bank #(.DEPTH(FLOW_ENTRIES), .IDX_W(IDX_W), .DATA_W(TIME_W)) u_last (
    .clk(clk), .rst(rst), .idx(idx1), .wr_en(v1),
    .wr_data(arr1), .rd_data(last_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) v2 <= 1'b0;
    else v2 <= v1;
  end

  always_ff @(posedge clk) begin
    idx2  <= idx1;
    cand2 <= cand1;
    arr2  <= arr1;
    last2 <= last_rd;
  end

  // Stage 3: elapsed time, modulo 2^TIME_W
  logic              v3;
  logic [IDX_W-1:0]  idx3;
  logic [HOP_W-1:0]  cand3;
  logic [TIME_W-1:0] gap3;

  always_ff @(posedge clk) begin
    if (rst) v3 <= 1'b0;
    else v3 <= v2;
  end

  always_ff @(posedge clk) begin
    idx3  <= idx2;
    cand3 <= cand2;
    gap3  <= arr2 - last2;
  end

  // Stage 4: strict threshold compare (R3)
  logic             v4;
  logic [IDX_W-1:0] idx4;
  logic [HOP_W-1:0] cand4;
  hop_pick_t        pick4;

  always_ff @(posedge clk) begin
    if (rst) v4 <= 1'b0;
    else v4 <= v3;
  end

  always_ff @(posedge clk) begin
    idx4  <= idx3;
    cand4 <= cand3;
    pick4 <= (gap3 > TIME_W'(IDLE_GAP)) ? PICK_FRESH : PICK_SAVED;
  end

  // Stage 5: pinned hop, read and conditionally rewritten in one cycle (R8)
  logic [HOP_W-1:0] saved_rd;
  logic             pin_wr;
  logic             v5;
  logic [HOP_W-1:0] cand5;
  logic [HOP_W-1:0] saved5;
  hop_pick_t        pick5;

  assign pin_wr = v4 && (pick4 == PICK_FRESH);

  state_bank #(.DEPTH(FLOW_ENTRIES), .IDX_W(IDX_W), .DATA_W(HOP_W)) u_pin (
    .clk(clk), .rst(rst), .idx(idx4), .wr_en(pin_wr),
    .wr_data(cand4), .rd_data(saved_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) v5 <= 1'b0;
    else v5 <= v4;
  end

  always_ff @(posedge clk) begin
    cand5  <= cand4;
    saved5 <= saved_rd;
    pick5  <= pick4;
  end

  // Stage 6: select and register the result (R5, R10)
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_hop   <= '0;
    end else begin
      out_valid <= v5;
      if (v5) out_hop <= (pick5 == PICK_FRESH) ? cand5 : saved5;
    end
  end
endmodule

// File: rtl/flowlet_nexthop_chk.sv
module flowlet_nexthop_chk #(
  parameter int unsigned NUM_HOPS = 10,
  parameter int unsigned HOP_W    = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             out_valid,
  input logic [HOP_W-1:0] out_hop
);
  logic [2:0] cyc_q;

  always_ff @(posedge clk) begin
    if (rst) cyc_q <= '0;
    else if (cyc_q != 3'd7) cyc_q <= cyc_q + 3'd1;
  end

  // R7
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc_q >= 3'd6) |-> (out_valid == $past(in_valid, 6)));

  // R11
  flush_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc_q < 3'd6) |-> !out_valid);

  // R5
  hop_range_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (32'(out_hop) < NUM_HOPS));

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((cyc_q != 3'd0) && !out_valid) |-> $stable(out_hop));
endmodule

bind flowlet_nexthop flowlet_nexthop_chk #(
  .NUM_HOPS(NUM_HOPS), .HOP_W(HOP_W)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid),
  .out_valid(out_valid), .out_hop(out_hop)
);

// File: tb/sim_flowlet_nexthop.sv
`timescale 1ns/1ps
module sim_flowlet_nexthop;
  localparam int ENTRIES = 2000;
  localparam int HOPS    = 10;
  localparam int GAP     = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] in_sport = '0;
  logic [15:0] in_dport = '0;
  logic [31:0] in_arrival = '0;
  logic        out_valid;
  logic [3:0]  out_hop;

  flowlet_nexthop u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sport(in_sport),
    .in_dport(in_dport), .in_arrival(in_arrival),
    .out_valid(out_valid), .out_hop(out_hop)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int    hop;
    int    at;
    string tag;
  } exp_t;
  exp_t sb[$];

  int compared = 0;
  int mismatched = 0;
  int last_hop = 0;
  bit done = 1'b0;

  logic [31:0] m_last [ENTRIES];
  int          m_pin  [ENTRIES];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int m_idx(input logic [15:0] s, input logic [15:0] d);
    logic [15:0] k;
    k = s ^ {d[7:0], d[15:8]};
    return int'(k) % ENTRIES;
  endfunction

  function automatic int m_cand(input logic [15:0] s, input logic [15:0] d, input logic [31:0] a);
    longint unsigned t;
    t = longint'(s) + longint'(d) + longint'(a);
    return int'(t % HOPS);
  endfunction

  task automatic send(input logic [15:0] s, input logic [15:0] d, input logic [31:0] a, input string tag);
    int          i;
    int          c;
    logic [31:0] g;
    exp_t        e;
    @(negedge clk);
    i = m_idx(s, d);
    c = m_cand(s, d, a);
    g = a - m_last[i];
    m_last[i] = a;
    if (g > 32'(GAP)) m_pin[i] = c;
    e.hop = m_pin[i];
    e.at  = cyc;
    e.tag = tag;
    sb.push_back(e);
    in_valid = 1'b1; in_sport = s; in_dport = d; in_arrival = a;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic junk(input logic [15:0] s, input logic [15:0] d, input logic [31:0] a);
    @(negedge clk);
    in_valid = 1'b0; in_sport = s; in_dport = d; in_arrival = a;
  endtask

  // Monitor: pops expected results as they leave the design
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (out_valid) begin
        if (sb.size() == 0) begin
          check(1'b0, "R7 result with no packet", int'(out_hop), -1);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(int'(out_hop) == e.hop, e.tag, int'(out_hop), e.hop);
          check(cyc - e.at == 6, "R7 latency", cyc - e.at, 6);
        end
        last_hop = int'(out_hop);
      end else begin
        check(int'(out_hop) == last_hop, "R10 hop held while idle", int'(out_hop), last_hop);
      end
    end
  end

  task automatic finish_run;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #750000;
    compared++;
    mismatched++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    for (int i = 0; i < ENTRIES; i++) begin
      m_last[i] = '0;
      m_pin[i]  = 0;
    end
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0, "R11 valid low in reset", int'(out_valid), 0);
    check(out_hop == 4'd0, "R6 hop zero in reset", int'(out_hop), 0);
    rst = 1'b0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R11 flush after reset", int'(out_valid), 0);
    end

    // Single flow, hand-picked gaps. Flow A = (100,200) sits in slot 1300.
    send(16'd100, 16'd200, 32'd3,  "R6 fresh slot reads zero");
    send(16'd100, 16'd200, 32'd8,  "R3 gap equal to limit keeps pin");
    send(16'd100, 16'd200, 32'd14, "R3 R5 gap over limit takes candidate");
    send(16'd100, 16'd200, 32'd15, "R8 back-to-back keeps pin");
    send(16'd100, 16'd200, 32'd16, "R8 back-to-back keeps pin");
    send(16'd100, 16'd200, 32'd17, "R8 back-to-back keeps pin");
    send(16'd100, 16'd200, 32'd30, "R5 new flowlet");
    send(16'd100, 16'd200, 32'd31, "R8 sees pin written one cycle earlier");
    idle(3);

    // Colliding pair (1300,0) shares slot 1300 with flow A.
    send(16'd1300, 16'd0, 32'd33, "R1 shared slot follows pin");
    // An invalid cycle carrying data that would reset the slot.
    junk(16'd100, 16'd200, 32'd1000);
    send(16'd100, 16'd200, 32'd36, "R9 invalid cycle ignored");

    // Last-seen refreshed on kept-pin packets.
    send(16'd100, 16'd200, 32'd40, "R4 refresh without change");
    send(16'd100, 16'd200, 32'd45, "R4 refresh without change");
    send(16'd100, 16'd200, 32'd50, "R4 refresh without change");

    // Timestamp wraps past 2^32.
    send(16'd7, 16'd7, 32'hFFFF_FFFE, "R3 large gap near wrap");
    send(16'd7, 16'd7, 32'd2,         "R3 wrapped gap of four");
    idle(4);

    // Random traffic over a few flows with bubbles.
    begin
      logic [15:0] fs [8];
      logic [15:0] fd [8];
      logic [31:0] ft [8];
      for (int f = 0; f < 8; f++) begin
        fs[f] = 16'($urandom_range(0, 65535));
        fd[f] = 16'($urandom_range(0, 65535));
        ft[f] = 32'($urandom_range(0, 1000));
      end
      fs[7] = 16'd1300; fd[7] = 16'd0;
      for (int n = 0; n < 3000; n++) begin
        int f;
        f = $urandom_range(0, 7);
        ft[f] = ft[f] + 32'($urandom_range(0, 9));
        send(fs[f], fd[f], ft[f], "R2 R5 random traffic");
        if ($urandom_range(0, 7) == 0) idle($urandom_range(1, 3));
      end
    end
    idle(10);
    check(sb.size() == 0, "R7 every packet produced a result", sb.size(), 0);
    finish_run();
  end
endmodule